// File: doc/BRIEF.md
# Indexed Framebuffer Control Register Bank

This block is the register bank of an 8-bit indexed framebuffer controller. A host reaches it over a simple 32-bit word bus with no byte enables. The bank holds a 256-entry colour lookup table and a three-colour cursor palette. It also holds a 512-word cursor bitmap and the frame geometry: horizontal size, vertical size, top-of-screen offset and cursor location. A control word selects blanking, cursor visibility and pixel depth. The scanout logic sees the frame-level fields as plain outputs. It also has two registered lookup ports, one into the colour table and one into the cursor bitmap.

Geometry registers hold scaled values. The horizontal register counts groups of four pixels. The vertical register counts half-lines, so odd values lose their low bit. Table entries sit 8 bytes apart in the address space. Writes to the boot and video timing addresses are accepted and dropped. A frame interrupt is set by a frame pulse from the scanout side and cleared by any bus write. One address acts as a soft reset that wipes all programmable state.

The bus has no back-pressure. Every request with `bus_sel` high is taken in its cycle. A write updates state at the clock edge that ends the request cycle. A read returns `rd_valid` with its data exactly one cycle later.

Top module: `fb_regbank`

## Requirements
- R1: A read request (bus_sel=1, bus_we=0) produces rd_valid=1 with rd_data in the following cycle only; writes never produce rd_valid, and no request is ever stalled.
- R2: A write to 0x118 stores bits 11:0 of the data as v; width_px then equals 4*v, and a read of 0x118 returns v.
- R3: A write to 0x150 stores (bits 11:0)/2 as the line count height_ln; a read of 0x150 returns height_ln*2, so an odd written value reads back one lower.
- R4: The 32-bit control word at 0x300 reads back as written; bit 10 set drives blank=1, bit 23 set drives cursor_en=0.
- R5: Control bits 22:20 give depth: 0→1, 1→2, 2→4, 3→8, 4→15, 5→16, 6 and 7→0.
- R6: A write to 0x800+8*i (i in 0..255) loads colour entry i with red=bits 23:16, green=15:8, blue=7:0; pix_rgb shows the entry selected by pix_idx one cycle after pix_idx is applied; the colour table is not readable from the bus (read gives zero with rd_err).
- R7: The cursor palette at 0x508+8*i (i in 0..2) is readable and writable with the same packing; entry i appears on cur_pal_rgb[24*i+23:24*i].
- R8: The cursor bitmap at 0x1000+8*i (i in 0..511) stores bits 15:0, is readable from the bus, and pat_word shows the word selected by pat_idx one cycle after pat_idx is applied.
- R9: Writes to 0x400 set top_offset to bits 23:0; writes to 0x638 set cursor_x to bits 23:12 and cursor_y to bits 11:0; both addresses are write-only.
- R10: Writes to 0x000, 0x108, 0x110, 0x120, 0x128, 0x130, 0x138, 0x140, 0x148, 0x158, 0x160, 0x168, 0x170 and 0x200 change no state other than clearing irq.
- R11: A read of an unmapped or write-only address returns rd_data=0 with rd_err=1 for that single response cycle.
- R12: A write to 0x100000 clears both palettes, the cursor bitmap, cursor position, control word, top offset, width and height, and lowers irq.
- R13: irq rises the cycle after frame_pulse and falls the cycle after any bus write; when both occur in one cycle irq is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 21 | Byte address |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data |
| rd_err | output | 1 | Read hit an unmapped or write-only address |
| frame_pulse | input | 1 | One frame finished on the scanout side |
| irq | output | 1 | Frame interrupt |
| blank | output | 1 | Force blank |
| cursor_en | output | 1 | Cursor visible |
| depth | output | 5 | Decoded bits per pixel (0 = unsupported) |
| width_px | output | 14 | Active width in pixels |
| height_ln | output | 11 | Active height in lines |
| top_offset | output | 24 | Frame start offset |
| cursor_x | output | 12 | Cursor column |
| cursor_y | output | 12 | Cursor row |
| cur_pal_rgb | output | 72 | Three packed cursor colours |
| pix_idx | input | 8 | Colour table lookup index |
| pix_rgb | output | 24 | Colour table lookup result |
| pat_idx | input | 9 | Cursor bitmap lookup index |
| pat_word | output | 16 | Cursor bitmap lookup result |

## Verification
The hardest case to reach from the ports is a frame pulse and a bus write landing in the same cycle. It is the only point where the set/clear priority of the interrupt shows. The bench drives both on one falling edge, so they meet at a single rising edge. A second hard case is proving that the soft reset really empties the colour table, since the bus cannot read it. Entries are written, the reset address is hit, and the lookup port is then swept over the entries.

// File: rtl/fb_regbank_pkg.sv
package fb_regbank_pkg;

  localparam int ADDR_W = 21;

  localparam logic [ADDR_W-1:0] A_CLUT_LO  = 21'h000800;
  localparam logic [ADDR_W-1:0] A_CLUT_HI  = 21'h001000;
  localparam logic [ADDR_W-1:0] A_BMP_LO   = 21'h001000;
  localparam logic [ADDR_W-1:0] A_BMP_HI   = 21'h002000;
  localparam logic [ADDR_W-1:0] A_CPAL_LO  = 21'h000508;
  localparam logic [ADDR_W-1:0] A_CPAL_HI  = 21'h000520;
  localparam logic [ADDR_W-1:0] A_HSIZE    = 21'h000118;
  localparam logic [ADDR_W-1:0] A_VSIZE    = 21'h000150;
  localparam logic [ADDR_W-1:0] A_MODE     = 21'h000300;
  localparam logic [ADDR_W-1:0] A_ORIGIN   = 21'h000400;
  localparam logic [ADDR_W-1:0] A_CURLOC   = 21'h000638;
  localparam logic [ADDR_W-1:0] A_WIPE     = 21'h100000;

  typedef enum logic [3:0] {
    RG_NONE, RG_CLUT, RG_BMP, RG_CPAL, RG_HSIZE, RG_VSIZE,
    RG_MODE, RG_ORIGIN, RG_CURLOC, RG_WIPE, RG_TIMING
  } region_e;

  localparam int MODE_BLANK_BIT  = 10;
  localparam int MODE_NOCUR_BIT  = 23;
  localparam int MODE_DEPTH_LSB  = 20;

  function automatic logic [4:0] depth_of(input logic [2:0] sel);
    case (sel)
      3'd0: depth_of = 5'd1;
      3'd1: depth_of = 5'd2;
      3'd2: depth_of = 5'd4;
      3'd3: depth_of = 5'd8;
      3'd4: depth_of = 5'd15;
      3'd5: depth_of = 5'd16;
      default: depth_of = 5'd0;
    endcase
  endfunction

endpackage

// File: rtl/fb_addr_decode.sv
module fb_addr_decode
  import fb_regbank_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [7:0]        clut_idx,
  output logic [8:0]        bmp_idx,
  output logic [1:0]        cpal_idx
);
  logic [ADDR_W-1:0] cpal_off;

  always_comb begin
    cpal_off = addr - A_CPAL_LO;
    clut_idx = addr[10:3];
    bmp_idx  = addr[11:3];
    cpal_idx = cpal_off[4:3];
    region   = RG_NONE;
    if (addr >= A_CLUT_LO && addr < A_CLUT_HI)      region = RG_CLUT;
    else if (addr >= A_BMP_LO && addr < A_BMP_HI)   region = RG_BMP;
    else if (addr >= A_CPAL_LO && addr < A_CPAL_HI) region = RG_CPAL;
    else begin
      case (addr)
        A_HSIZE:  region = RG_HSIZE;
        A_VSIZE:  region = RG_VSIZE;
        A_MODE:   region = RG_MODE;
        A_ORIGIN: region = RG_ORIGIN;
        A_CURLOC: region = RG_CURLOC;
        A_WIPE:   region = RG_WIPE;
        21'h000000, 21'h000108, 21'h000110, 21'h000120, 21'h000128,
        21'h000130, 21'h000138, 21'h000140, 21'h000148, 21'h000158,
        21'h000160, 21'h000168, 21'h000170, 21'h000200:
                  region = RG_TIMING;
        default:  region = RG_NONE;
      endcase
    end
  end
endmodule

// File: rtl/fb_entry_store.sv
module fb_entry_store #(
  parameter int DEPTH = 256,
  parameter int W     = 24,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ridx,
  output logic [W-1:0]  rdata,
  input  logic [IW-1:0] lidx,
  output logic [W-1:0]  ldata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ldata <= '0;
    else        ldata <= mem[lidx];
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/fb_frame_irq.sv
module fb_frame_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_pulse,
  input  logic bus_wr,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)           irq <= 1'b0;
    else if (frame_pulse) irq <= 1'b1;
    else if (bus_wr)      irq <= 1'b0;
  end
endmodule

// File: rtl/fb_regbank.sv
module fb_regbank
  import fb_regbank_pkg::*;
#(
  parameter int GEOM_W = 12,
  parameter int TOP_W  = 24,
  parameter int POS_W  = 12,
  parameter int CLUT_N = 256,
  parameter int BMP_N  = 512
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic                  rd_valid,
  output logic [31:0]           rd_data,
  output logic                  rd_err,
  input  logic                  frame_pulse,
  output logic                  irq,
  output logic                  blank,
  output logic                  cursor_en,
  output logic [4:0]            depth,
  output logic [GEOM_W+1:0]     width_px,
  output logic [GEOM_W-2:0]     height_ln,
  output logic [TOP_W-1:0]      top_offset,
  output logic [POS_W-1:0]      cursor_x,
  output logic [POS_W-1:0]      cursor_y,
  output logic [71:0]           cur_pal_rgb,
  input  logic [$clog2(CLUT_N)-1:0] pix_idx,
  output logic [23:0]           pix_rgb,
  input  logic [$clog2(BMP_N)-1:0]  pat_idx,
  output logic [15:0]           pat_word
);
  localparam int CI_W = $clog2(CLUT_N);
  localparam int BI_W = $clog2(BMP_N);
  localparam int CPAL_N = 3;

  region_e    region;
  logic [7:0] clut_idx_d;
  logic [8:0] bmp_idx_d;
  logic [1:0] cpal_idx_d;

  fb_addr_decode u_dec (
    .addr     (bus_addr),
    .region   (region),
    .clut_idx (clut_idx_d),
    .bmp_idx  (bmp_idx_d),
    .cpal_idx (cpal_idx_d)
  );

  logic wr, rd, wipe;
  assign wr   = bus_sel & bus_we;
  assign rd   = bus_sel & ~bus_we;
  assign wipe = wr && (region == RG_WIPE);

  logic [31:0]            mode_q;
  logic [GEOM_W-1:0]      hsize_q;
  logic [GEOM_W-2:0]      vsize_q;
  logic [TOP_W-1:0]       origin_q;
  logic [2*POS_W-1:0]     curloc_q;
  logic [CPAL_N-1:0][23:0] cpal_q;

  always_ff @(posedge clk) begin
    if (!rst_n || wipe) begin
      mode_q   <= '0;
      hsize_q  <= '0;
      vsize_q  <= '0;
      origin_q <= '0;
      curloc_q <= '0;
    end else if (wr) begin
      case (region)
        RG_MODE:   mode_q   <= bus_wdata;
        RG_HSIZE:  hsize_q  <= bus_wdata[GEOM_W-1:0];
        RG_VSIZE:  vsize_q  <= bus_wdata[GEOM_W-1:1];
        RG_ORIGIN: origin_q <= bus_wdata[TOP_W-1:0];
        RG_CURLOC: curloc_q <= bus_wdata[2*POS_W-1:0];
        default: ;
      endcase
    end
  end

  generate
    for (genvar g = 0; g < CPAL_N; g++) begin : g_cpal
      always_ff @(posedge clk) begin
        if (!rst_n || wipe)
          cpal_q[g] <= '0;
        else if (wr && region == RG_CPAL && cpal_idx_d == 2'(g))
          cpal_q[g] <= bus_wdata[23:0];
      end
    end
  endgenerate

  logic [23:0] clut_rd_unused;
  logic [15:0] bmp_rd;

  fb_entry_store #(.DEPTH(CLUT_N), .W(24)) u_clut (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (wipe),
    .we    (wr && region == RG_CLUT),
    .widx  (clut_idx_d[CI_W-1:0]),
    .wdata (bus_wdata[23:0]),
    .ridx  (pix_idx),
    .rdata (clut_rd_unused),
    .lidx  (pix_idx),
    .ldata (pix_rgb)
  );

  fb_entry_store #(.DEPTH(BMP_N), .W(16)) u_bmp (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (wipe),
    .we    (wr && region == RG_BMP),
    .widx  (bmp_idx_d[BI_W-1:0]),
    .wdata (bus_wdata[15:0]),
    .ridx  (bmp_idx_d[BI_W-1:0]),
    .rdata (bmp_rd),
    .lidx  (pat_idx),
    .ldata (pat_word)
  );

  fb_frame_irq u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_pulse (frame_pulse),
    .bus_wr      (wr),
    .irq         (irq)
  );

  logic [31:0] rmux;
  logic        rbad;
  always_comb begin
    rmux = '0;
    rbad = 1'b0;
    case (region)
      RG_BMP:   rmux = {16'd0, bmp_rd};
      RG_CPAL:  rmux = (cpal_idx_d < 2'(CPAL_N)) ? {8'd0, cpal_q[cpal_idx_d]} : '0;
      RG_HSIZE: rmux = 32'(hsize_q);
      RG_VSIZE: rmux = 32'({vsize_q, 1'b0});
      RG_MODE:  rmux = mode_q;
      default:  rbad = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_err   <= 1'b0;
    end else begin
      rd_valid <= rd;
      rd_err   <= rd & rbad;
      rd_data  <= rd ? rmux : '0;
    end
  end

  assign blank       = mode_q[MODE_BLANK_BIT];
  assign cursor_en   = ~mode_q[MODE_NOCUR_BIT];
  assign depth       = depth_of(mode_q[MODE_DEPTH_LSB +: 3]);
  assign width_px    = {hsize_q, 2'b00};
  assign height_ln   = vsize_q;
  assign top_offset  = origin_q;
  assign cursor_x    = curloc_q[2*POS_W-1:POS_W];
  assign cursor_y    = curloc_q[POS_W-1:0];
  assign cur_pal_rgb = cpal_q;
endmodule

// File: rtl/fb_regbank_chk.sv
module fb_regbank_chk
  import fb_regbank_pkg::*;
#(
  parameter int GEOM_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              rd_valid,
  input logic [31:0]       rd_data,
  input logic              rd_err,
  input logic              frame_pulse,
  input logic              irq,
  input logic              blank,
  input logic              cursor_en,
  input logic [GEOM_W+1:0] width_px,
  input logic [GEOM_W-2:0] height_ln
);
  assert_read_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we) |=> rd_valid);

  assert_no_spurious_resp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_we) |=> !rd_valid);

  assert_width_scale_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == A_HSIZE) |=>
      width_px == {$past(bus_wdata[GEOM_W-1:0]), 2'b00});

  assert_blank_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == A_MODE) |=>
      (blank == $past(bus_wdata[10])) && (cursor_en != $past(bus_wdata[23])));

  assert_err_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> (rd_valid && rd_data == 32'd0));

  assert_wipe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == A_WIPE) |=>
      (width_px == '0 && height_ln == '0 && !blank && cursor_en));

  assert_irq_set_R13: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |=> irq);

  assert_irq_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && !frame_pulse) |=> !irq);
endmodule

bind fb_regbank fb_regbank_chk #(.GEOM_W(GEOM_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_sel     (bus_sel),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .rd_valid    (rd_valid),
  .rd_data     (rd_data),
  .rd_err      (rd_err),
  .frame_pulse (frame_pulse),
  .irq         (irq),
  .blank       (blank),
  .cursor_en   (cursor_en),
  .width_px    (width_px),
  .height_ln   (height_ln)
);

// File: tb/test_fb_regbank.sv
module test_fb_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [20:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rd_valid, rd_err, irq, blank, cursor_en;
  logic [31:0] rd_data;
  logic        frame_pulse = 1'b0;
  logic [4:0]  depth;
  logic [13:0] width_px;
  logic [10:0] height_ln;
  logic [23:0] top_offset, pix_rgb;
  logic [11:0] cursor_x, cursor_y;
  logic [71:0] cur_pal_rgb;
  logic [7:0]  pix_idx = '0;
  logic [8:0]  pat_idx = '0;
  logic [15:0] pat_word;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fb_regbank i_fb_regbank (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_err(rd_err), .frame_pulse(frame_pulse),
    .irq(irq), .blank(blank), .cursor_en(cursor_en), .depth(depth),
    .width_px(width_px), .height_ln(height_ln), .top_offset(top_offset),
    .cursor_x(cursor_x), .cursor_y(cursor_y), .cur_pal_rgb(cur_pal_rgb),
    .pix_idx(pix_idx), .pix_rgb(pix_rgb), .pat_idx(pat_idx), .pat_word(pat_word)
  );

  task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [20:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [20:0] a, output logic [31:0] d, output logic e, output logic v);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = rd_data; e = rd_err; v = rd_valid;
  endtask

  task automatic rd_expect(input string req, input logic [20:0] a,
                           input logic [31:0] exp, input logic exp_err);
    logic [31:0] d; logic e, v;
    rd(a, d, e, v);
    chk({req, " valid"}, 72'(v), 72'(1));
    chk({req, " data"}, 72'(d), 72'(exp));
    chk({req, " err"}, 72'(e), 72'(exp_err));
  endtask

  task automatic t_reset;
    chk("R1 reset rd_valid", 72'(rd_valid), 72'(0));
    chk("R13 reset irq", 72'(irq), 72'(0));
    chk("R2 reset width", 72'(width_px), 72'(0));
    chk("R4 reset blank/cursor", 72'({blank, cursor_en}), 72'(2'b01));
    chk("R5 reset depth", 72'(depth), 72'(1));
  endtask

  task automatic t_latency;
    wr(21'h000300, 32'h0);
    chk("R1 write gives no response", 72'(rd_valid), 72'(0));
    rd_expect("R1 read", 21'h000300, 32'h0, 1'b0);
    @(negedge clk);
    chk("R1 response lasts one cycle", 72'(rd_valid), 72'(0));
  endtask

  task automatic t_geometry;
    wr(21'h000118, 32'h0000_0140);
    chk("R2 width 4x", 72'(width_px), 72'(14'h500));
    rd_expect("R2 width read", 21'h000118, 32'h140, 1'b0);
    wr(21'h000118, 32'hFFFF_F005);
    rd_expect("R2 width upper bits dropped", 21'h000118, 32'h005, 1'b0);
    wr(21'h000150, 32'h7);
    chk("R3 height half", 72'(height_ln), 72'(3));
    rd_expect("R3 odd height reads lower", 21'h000150, 32'h6, 1'b0);
    wr(21'h000150, 32'h3C0);
    chk("R3 height even", 72'(height_ln), 72'(11'h1E0));
  endtask

  task automatic t_mode;
    wr(21'h000300, 32'h0080_0400);
    chk("R4 blank and cursor off", 72'({blank, cursor_en}), 72'(2'b10));
    rd_expect("R4 mode readback", 21'h000300, 32'h0080_0400, 1'b0);
    for (int s = 0; s < 8; s++) begin
      logic [4:0] exp;
      case (s)
        0: exp = 1; 1: exp = 2; 2: exp = 4; 3: exp = 8;
        4: exp = 15; 5: exp = 16; default: exp = 0;
      endcase
      wr(21'h000300, 32'(s) << 20);
      chk($sformatf("R5 depth sel %0d", s), 72'(depth), 72'(exp));
    end
  endtask

  task automatic t_clut;
    wr(21'h000800, 32'hFF12_3456);
    wr(21'h000828, 32'h00AB_CDEF);
    wr(21'h000FF8, 32'h0001_0203);
    @(negedge clk); pix_idx = 8'd5;
    @(negedge clk); chk("R6 lookup idx 5", 72'(pix_rgb), 72'(24'hABCDEF));
    pix_idx = 8'd0;
    @(negedge clk); chk("R6 lookup idx 0", 72'(pix_rgb), 72'(24'h123456));
    pix_idx = 8'd255;
    @(negedge clk); chk("R6 lookup idx 255", 72'(pix_rgb), 72'(24'h010203));
    rd_expect("R6 clut not readable", 21'h000828, 32'h0, 1'b1);
  endtask

  task automatic t_cpal;
    wr(21'h000508, 32'h00_1111_11);
    wr(21'h000510, 32'hAA_2222_22);
    wr(21'h000518, 32'h00_3333_33);
    chk("R7 cursor palette outputs", cur_pal_rgb, {24'h333333, 24'h222222, 24'h111111});
    rd_expect("R7 cursor palette read 1", 21'h000510, 32'h0022_2222, 1'b0);
    rd_expect("R11 past cursor palette", 21'h000520, 32'h0, 1'b1);
  endtask

  task automatic t_bitmap;
    wr(21'h001000, 32'hDEAD_BEEF);
    wr(21'h001FF8, 32'h0000_1234);
    rd_expect("R8 bitmap read 0", 21'h001000, 32'h0000_BEEF, 1'b0);
    rd_expect("R8 bitmap read 511", 21'h001FF8, 32'h0000_1234, 1'b0);
    @(negedge clk); pat_idx = 9'd511;
    @(negedge clk); chk("R8 bitmap lookup", 72'(pat_word), 72'(16'h1234));
  endtask

  task automatic t_writeonly;
    wr(21'h000400, 32'hFF65_4321);
    chk("R9 top offset", 72'(top_offset), 72'(24'h654321));
    wr(21'h000638, 32'h0012_3045);
    chk("R9 cursor xy", 72'({cursor_x, cursor_y}), 72'({12'h123, 12'h045}));
    rd_expect("R9 top write-only", 21'h000400, 32'h0, 1'b1);
    rd_expect("R9 cursor write-only", 21'h000638, 32'h0, 1'b1);
  endtask

  task automatic t_timing;
    logic [20:0] tl [14] = '{21'h000, 21'h108, 21'h110, 21'h120, 21'h128, 21'h130,
                             21'h138, 21'h140, 21'h148, 21'h158, 21'h160, 21'h168,
                             21'h170, 21'h200};
    wr(21'h000300, 32'h0030_0000);
    for (int k = 0; k < 14; k++) wr(tl[k], 32'hFFFF_FFFF);
    rd_expect("R10 mode untouched", 21'h000300, 32'h0030_0000, 1'b0);
    rd_expect("R10 width untouched", 21'h000118, 32'h005, 1'b0);
    chk("R10 geometry outputs", 72'({top_offset, cursor_x, cursor_y}),
        72'({24'h654321, 12'h123, 12'h045}));
    rd_expect("R10 timing read errs", 21'h000158, 32'h0, 1'b1);
  endtask

  task automatic t_unmapped;
    rd_expect("R11 unmapped", 21'h000004, 32'h0, 1'b1);
    @(negedge clk);
    chk("R11 err one cycle", 72'(rd_err), 72'(0));
    rd_expect("R11 wipe addr read", 21'h100000, 32'h0, 1'b1);
  endtask

  task automatic t_irq;
    @(negedge clk); frame_pulse = 1'b1;
    @(negedge clk); frame_pulse = 1'b0;
    chk("R13 set by frame", 72'(irq), 72'(1));
    @(negedge clk);
    chk("R13 held", 72'(irq), 72'(1));
    wr(21'h000108, 32'h0);
    chk("R13 cleared by write", 72'(irq), 72'(0));
    @(negedge clk);
    frame_pulse = 1'b1; bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 21'h000108;
    @(negedge clk);
    frame_pulse = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
    chk("R13 set wins over clear", 72'(irq), 72'(1));
  endtask

  task automatic t_wipe;
    wr(21'h000300, 32'h0080_0400);
    wr(21'h100000, 32'h0);
    chk("R12 irq lowered", 72'(irq), 72'(0));
    chk("R12 geometry cleared", 72'({width_px, height_ln, top_offset, cursor_x, cursor_y}), 72'(0));
    chk("R12 mode outputs", 72'({blank, cursor_en, depth}), 72'({2'b01, 5'd1}));
    chk("R12 cursor palette", cur_pal_rgb, 72'(0));
    rd_expect("R12 bitmap cleared", 21'h001000, 32'h0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); pix_idx = (k == 0) ? 8'd0 : (k == 1) ? 8'd5 : 8'd255;
      @(negedge clk); chk("R12 clut cleared", 72'(pix_rgb), 72'(0));
    end
    @(negedge clk); chk("R12 bitmap lookup cleared", 72'(pat_word), 72'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_geometry();
    t_mode();
    t_clut();
    t_cpal();
    t_bitmap();
    t_writeonly();
    t_timing();
    t_unmapped();
    t_irq();
    t_wipe();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule